// File: doc/BRIEF.md
# Data-Dependent Ripple ALU

This block is a 32-bit arithmetic/logic unit whose adder is a bare chain of full adders with no carry acceleration. The carry into every bit position is held as a two-wire code that is unknown, known-zero or known-one. On each clock, any bit whose lower carry has just become known passes that value up one place. The add finishes as soon as every carry in the word is known, so short carry chains finish in few cycles and only a full-width propagate pattern costs the full word length.

Besides addition the unit performs move-B, AND, OR and XOR. Before the operation, each operand bus can be forced to zero and/or inverted, which also gives pass-A and constant results. A caller raises `start` for one cycle with opcode, modifiers and operands. It then waits for the one-cycle `done` pulse, when `result` and `carry_out` are valid. They hold until the next accepted start.

Top module: `rip_alu`

## Requirements
- R1: After reset, `done`, `result` and `carry_out` are all zero.
- R2: Opcode 000 returns operand B, 001 returns A AND B, 010 returns A OR B, 011 returns A XOR B, and 100 returns the sum. All operands are taken after modification.
- R3: Each operand is modified as (force-zero ? 0 : operand) XOR (invert ? all-ones : 0). Zero plus invert therefore gives all ones, and pass-A is OR with B forced to zero.
- R4: Any opcode other than 100 raises `done` in the cycle after the start cycle. Codes 101, 110 and 111 return zero.
- R5: For opcode 100, {`carry_out`,`result`} equals A' + B' + `carry_in` while `done` is high.
- R6: An add raises `done` exactly 1 + L cycles after the start cycle. L is the longest run of consecutive bit positions where A' and B' differ; L is 0 when there is no such position.
- R7: `done` is high for exactly one cycle per accepted start. `result` and `carry_out` keep their values until the next accepted start.
- R8: `start` is accepted only when the unit is idle. A start raised from the accepted start up to and including the done cycle is ignored, with no effect on the result and no extra done pulse.
- R9: `carry_out` is zero after any operation other than add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation (sampled when idle) |
| opcode | input | 3 | Operation select |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| inv_a | input | 1 | Invert operand A |
| inv_b | input | 1 | Invert operand B |
| zero_a | input | 1 | Force operand A to zero |
| zero_b | input | 1 | Force operand B to zero |
| carry_in | input | 1 | Carry into bit 0 for add |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Carry out of the top bit (add only) |

## Verification
Some carry faults show no data error at all. A carry cell that resolves too early, or that copies a lower carry still unknown, surfaces first as a `done` that arrives before 1 + L cycles, even where the sum happens to be right. So the latency of every add is compared with the longest propagate run computed from the operands. A carry that resolves to the wrong value shows in `result` or `carry_out` at the very done pulse. A control fault shows in the cycles around it as a missing, doubled or late `done`, or as a result changed by a start raised while busy. Full-width propagate operands give the 33-cycle worst case, and all-generate or all-kill operands give the one-cycle best case.

// File: rtl/rip_alu_pkg.sv
package rip_alu_pkg;

   localparam logic [2:0] OPC_MOVB = 3'b000;
   localparam logic [2:0] OPC_AND  = 3'b001;
   localparam logic [2:0] OPC_OR   = 3'b010;
   localparam logic [2:0] OPC_XOR  = 3'b011;
   localparam logic [2:0] OPC_ADD  = 3'b100;

   // two-wire carry: 00 unresolved, 01 resolved low, 10 resolved high
   typedef struct packed {
      logic is_one;
      logic is_zero;
   } dr_bit_t;

   localparam dr_bit_t DR_UNSET = '{is_one: 1'b0, is_zero: 1'b0};

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_LOGIC = 2'd1,
      SEQ_ADD   = 2'd2
   } seq_state_e;

   function automatic dr_bit_t dr_encode(input logic v);
      dr_bit_t r;
      r.is_one  = v;
      r.is_zero = ~v;
      return r;
   endfunction

   function automatic logic dr_resolved(input dr_bit_t d);
      return d.is_one | d.is_zero;
   endfunction

endpackage

// File: rtl/rip_alu_opmod.sv
module rip_alu_opmod #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] raw,
   input  logic             force_zero,
   input  logic             invert,
   output logic [WIDTH-1:0] shaped
);
   always_comb begin
      shaped = (force_zero ? '0 : raw) ^ {WIDTH{invert}};
   end
endmodule

// File: rtl/rip_alu_logic.sv
module rip_alu_logic
   import rip_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [2:0]       opcode,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] y
);
   always_comb begin
      unique case (opcode)
         OPC_MOVB: y = b;
         OPC_AND:  y = a & b;
         OPC_OR:   y = a | b;
         OPC_XOR:  y = a ^ b;
         default:  y = '0;
      endcase
   end
endmodule

// File: rtl/rip_alu_cell.sv
module rip_alu_cell
   import rip_alu_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    load,
   input  logic    a_new,
   input  logic    b_new,
   input  logic    a_cur,
   input  logic    b_cur,
   input  dr_bit_t carry_lo,
   output dr_bit_t carry_hi,
   output logic    sum_bit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_hi <= DR_UNSET;
      end else if (load) begin
         // generate or kill resolves at once; propagate waits for the lower carry
         carry_hi <= (a_new == b_new) ? dr_encode(a_new) : DR_UNSET;
      end else if (!dr_resolved(carry_hi) && (a_cur != b_cur) && dr_resolved(carry_lo)) begin
         carry_hi <= carry_lo;
      end
   end

   always_comb begin
      sum_bit = a_cur ^ b_cur ^ carry_lo.is_one;
   end
endmodule

// File: rtl/rip_alu_chain.sv
module rip_alu_chain
   import rip_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic [WIDTH-1:0] known_vec,
   output logic             all_known
);
   logic [WIDTH-1:0] a_q;
   logic [WIDTH-1:0] b_q;
   dr_bit_t          carry_q [WIDTH+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q        <= '0;
         b_q        <= '0;
         carry_q[0] <= DR_UNSET;
      end else if (load) begin
         a_q        <= a_in;
         b_q        <= b_in;
         carry_q[0] <= dr_encode(cin);
      end
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      rip_alu_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load),
         .a_new    (a_in[i]),
         .b_new    (b_in[i]),
         .a_cur    (a_q[i]),
         .b_cur    (b_q[i]),
         .carry_lo (carry_q[i]),
         .carry_hi (carry_q[i+1]),
         .sum_bit  (sum[i])
      );
      assign known_vec[i] = dr_resolved(carry_q[i+1]);
   end

   assign all_known = &known_vec;
   assign cout      = carry_q[WIDTH].is_one;
endmodule

// File: rtl/rip_alu_seq.sv
module rip_alu_seq
   import rip_alu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_add,
   input  logic all_known,
   output logic load_add,
   output logic load_logic,
   output logic done,
   output logic idle
);
   seq_state_e st_q, st_d;
   logic       accept;

   always_comb begin
      idle       = (st_q == SEQ_IDLE);
      accept     = start && idle;
      load_add   = accept && is_add;
      load_logic = accept && !is_add;
      done       = (st_q == SEQ_LOGIC) || ((st_q == SEQ_ADD) && all_known);
      st_d       = st_q;
      unique case (st_q)
         SEQ_IDLE:  if (accept) st_d = is_add ? SEQ_ADD : SEQ_LOGIC;
         SEQ_LOGIC: st_d = SEQ_IDLE;
         SEQ_ADD:   if (all_known) st_d = SEQ_IDLE;
         default:   st_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SEQ_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/rip_alu.sv
module rip_alu
   import rip_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [2:0]       opcode,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             inv_a,
   input  logic             inv_b,
   input  logic             zero_a,
   input  logic             zero_b,
   input  logic             carry_in,
   output logic             done,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);
   if (WIDTH < 2) begin : g_width_check
      $error("rip_alu: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] a_mod, b_mod, logic_y, logic_q, sum;
   logic [WIDTH-1:0] carry_known;
   logic             cout, all_known, load_add, load_logic, seq_idle;
   logic             mode_add_q;

   rip_alu_opmod #(.WIDTH(WIDTH)) u_mod_a (
      .raw(op_a), .force_zero(zero_a), .invert(inv_a), .shaped(a_mod));
   rip_alu_opmod #(.WIDTH(WIDTH)) u_mod_b (
      .raw(op_b), .force_zero(zero_b), .invert(inv_b), .shaped(b_mod));

   rip_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .opcode(opcode), .a(a_mod), .b(b_mod), .y(logic_y));

   rip_alu_chain #(.WIDTH(WIDTH)) u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_add),
      .a_in      (a_mod),
      .b_in      (b_mod),
      .cin       (carry_in),
      .sum       (sum),
      .cout      (cout),
      .known_vec (carry_known),
      .all_known (all_known)
   );

   rip_alu_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .is_add     (opcode == OPC_ADD),
      .all_known  (all_known),
      .load_add   (load_add),
      .load_logic (load_logic),
      .done       (done),
      .idle       (seq_idle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         logic_q    <= '0;
         mode_add_q <= 1'b0;
      end else if (load_logic) begin
         logic_q    <= logic_y;
         mode_add_q <= 1'b0;
      end else if (load_add) begin
         mode_add_q <= 1'b1;
      end
   end

   assign result    = mode_add_q ? sum : logic_q;
   assign carry_out = mode_add_q & cout;
endmodule

// File: rtl/rip_alu_chk.sv
module rip_alu_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [2:0]       opcode,
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic             inv_a,
   input logic             inv_b,
   input logic             zero_a,
   input logic             zero_b,
   input logic             carry_in,
   input logic             done,
   input logic [WIDTH-1:0] result,
   input logic             carry_out,
   input logic             seq_idle,
   input logic [WIDTH-1:0] carry_known
);
   localparam int CW = $clog2(WIDTH + 2) + 1;

   logic [WIDTH:0]   ref_sum_q;
   logic             ref_add_q;
   logic [CW-1:0]    lat_q;
   logic [WIDTH-1:0] am, bm;

   always_comb begin
      am = (zero_a ? '0 : op_a) ^ {WIDTH{inv_a}};
      bm = (zero_b ? '0 : op_b) ^ {WIDTH{inv_b}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_sum_q <= '0;
         ref_add_q <= 1'b0;
         lat_q     <= '0;
      end else if (start && seq_idle) begin
         ref_sum_q <= {1'b0, am} + {1'b0, bm} + {{WIDTH{1'b0}}, carry_in};
         ref_add_q <= (opcode == 3'b100);
         lat_q     <= CW'(1);
      end else if (!seq_idle) begin
         lat_q     <= lat_q + CW'(1);
      end
   end

   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_quick_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && seq_idle && opcode != 3'b100) |=> done);

   assert_add_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ref_add_q) |-> ({carry_out, result} == ref_sum_q));

   assert_latency_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q <= CW'(WIDTH + 1)));

   assert_known_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_idle && $past(!seq_idle)) |-> ($countones(carry_known) >= $countones($past(carry_known))));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_idle && !start) |=> ($stable(result) && $stable(carry_out)));

   assert_logic_no_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ref_add_q) |-> !carry_out);
endmodule

bind rip_alu rip_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .opcode      (opcode),
   .op_a        (op_a),
   .op_b        (op_b),
   .inv_a       (inv_a),
   .inv_b       (inv_b),
   .zero_a      (zero_a),
   .zero_b      (zero_b),
   .carry_in    (carry_in),
   .done        (done),
   .result      (result),
   .carry_out   (carry_out),
   .seq_idle    (seq_idle),
   .carry_known (carry_known)
);

// File: tb/rip_alu_tb_top.sv
module rip_alu_tb_top;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [2:0]   opcode = '0;
   logic [W-1:0] op_a = '0, op_b = '0;
   logic         inv_a = 0, inv_b = 0, zero_a = 0, zero_b = 0, carry_in = 0;
   logic         done;
   logic [W-1:0] result;
   logic         carry_out;

   int n_checks = 0;
   int n_errors = 0;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   always #5 clk = ~clk;

   rip_alu #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .op_a(op_a), .op_b(op_b), .inv_a(inv_a), .inv_b(inv_b),
      .zero_a(zero_a), .zero_b(zero_b), .carry_in(carry_in),
      .done(done), .result(result), .carry_out(carry_out));

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [W-1:0] shape(input logic [W-1:0] x, input logic z, input logic i);
      return (z ? '0 : x) ^ {W{i}};
   endfunction

   function automatic int longest_run(input logic [W-1:0] p);
      int best = 0;
      int cur = 0;
      for (int k = 0; k < W; k++) begin
         cur = p[k] ? cur + 1 : 0;
         if (cur > best) best = cur;
      end
      return best;
   endfunction

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   // drive one operation and compare result, carry, latency and hold behaviour
   task automatic run_op(input string req, input logic [2:0] opc, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ia, input logic ib, input logic za, input logic zb, input logic ci);
      logic [W-1:0] am, bm, exp_r;
      logic         exp_c;
      int           exp_lat, lat;
      logic [W:0]   s;
      am = shape(a, za, ia);
      bm = shape(b, zb, ib);
      exp_c = 1'b0;
      exp_lat = 1;
      case (opc)
         3'b000: exp_r = bm;
         3'b001: exp_r = am & bm;
         3'b010: exp_r = am | bm;
         3'b011: exp_r = am ^ bm;
         3'b100: begin
            s = {1'b0, am} + {1'b0, bm} + {{W{1'b0}}, ci};
            exp_r = s[W-1:0];
            exp_c = s[W];
            exp_lat = 1 + longest_run(am ^ bm);
         end
         default: exp_r = '0;
      endcase
      @(negedge clk);
      opcode = opc; op_a = a; op_b = b; inv_a = ia; inv_b = ib;
      zero_a = za; zero_b = zb; carry_in = ci; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      lat = 1;
      while (!done && lat < 100) begin
         @(posedge clk); #1;
         lat++;
      end
      check(req, "result", {32'd0, result}, {32'd0, exp_r});
      check(req, "carry_out", {63'd0, carry_out}, {63'd0, exp_c});
      check((opc == 3'b100) ? "R6" : "R4", "latency", 64'(lat), 64'(exp_lat));
      @(posedge clk); #1;
      check("R7", "done falls", {63'd0, done}, 64'd0);
      check("R7", "result held", {32'd0, result}, {32'd0, exp_r});
   endtask

   task automatic t_reset();
      check("R1", "done after reset", {63'd0, done}, 64'd0);
      check("R1", "result after reset", {32'd0, result}, 64'd0);
      check("R1", "carry after reset", {63'd0, carry_out}, 64'd0);
   endtask

   task automatic t_logic();
      run_op("R2", 3'b000, 32'hDEAD_BEEF, 32'h1234_5678, 0, 0, 0, 0, 0);
      run_op("R2", 3'b001, 32'hF0F0_A5A5, 32'hFF00_0FF0, 0, 0, 0, 0, 1);
      run_op("R2", 3'b010, 32'h0F0F_0001, 32'h3000_8000, 0, 0, 0, 0, 0);
      run_op("R2", 3'b011, 32'hAAAA_5555, 32'hFFFF_0000, 0, 0, 0, 0, 1);
      // R9: an add leaving carry 1 followed by a logic op must clear carry_out
      run_op("R5", 3'b100, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0, 0, 0);
      run_op("R9", 3'b011, 32'h1234_0000, 32'h0000_4321, 0, 0, 0, 0, 1);
   endtask

   task automatic t_modifiers();
      run_op("R3", 3'b010, 32'hCAFE_F00D, 32'h5555_5555, 0, 0, 0, 1, 0); // pass A
      run_op("R3", 3'b000, 32'h1111_1111, 32'h7777_7777, 0, 0, 0, 1, 0); // constant zero
      run_op("R3", 3'b000, 32'h1111_1111, 32'h7777_7777, 0, 1, 0, 1, 0); // all ones
      run_op("R3", 3'b001, 32'h0F0F_0F0F, 32'h00FF_00FF, 1, 1, 0, 0, 0); // NOR by inversion
      run_op("R3", 3'b100, 32'h0000_0005, 32'h0000_0003, 0, 1, 0, 0, 1); // subtract
   endtask

   task automatic t_unused();
      run_op("R4", 3'b101, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 1);
      run_op("R4", 3'b110, 32'h8000_0001, 32'h8000_0001, 0, 0, 0, 0, 0);
      run_op("R4", 3'b111, 32'h0000_FFFF, 32'hFFFF_0000, 1, 0, 0, 0, 1);
   endtask

   task automatic t_add_directed();
      run_op("R5", 3'b100, 32'h0000_0000, 32'h0000_0000, 0, 0, 0, 0, 0); // all kill, latency 1
      run_op("R5", 3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 1); // all generate
      run_op("R5", 3'b100, 32'hFFFF_FFFF, 32'h0000_0000, 0, 0, 0, 0, 1); // full propagate, 33
      run_op("R5", 3'b100, 32'h0000_FFFF, 32'h0000_0000, 0, 0, 0, 0, 1); // low run of 16
      run_op("R5", 3'b100, 32'hFFFF_0000, 32'h0000_0001, 0, 0, 0, 0, 0); // high run of 16
      run_op("R5", 3'b100, 32'h5555_5555, 32'h0000_0000, 0, 0, 0, 0, 1); // isolated propagates
      run_op("R5", 3'b100, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 0, 0, 0); // overflow into msb
   endtask

   task automatic t_add_random();
      logic [W-1:0] a, b;
      logic [4:0]   m;
      for (int k = 0; k < 24; k++) begin
         lfsr = next_rand(lfsr); a = lfsr;
         lfsr = next_rand(lfsr); b = lfsr;
         lfsr = next_rand(lfsr); m = lfsr[4:0];
         run_op("R6", 3'b100, a, b, m[0], m[1], m[2] & m[3], 1'b0, m[4]);
      end
   endtask

   task automatic t_busy();
      int lat;
      logic saw_extra;
      @(negedge clk);
      opcode = 3'b100; op_a = 32'hFFFF_FFFF; op_b = 32'h0; inv_a = 0; inv_b = 0;
      zero_a = 0; zero_b = 0; carry_in = 1'b1; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      lat = 1;
      // raise start with different request while the add runs
      @(negedge clk);
      opcode = 3'b001; op_a = 32'h0; op_b = 32'h1234_5678; carry_in = 1'b0; start = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #1;
         lat++;
      end
      start = 1'b0;
      while (!done && lat < 100) begin
         @(posedge clk); #1;
         lat++;
      end
      check("R8", "busy add latency", 64'(lat), 64'd33);
      check("R8", "busy add result", {32'd0, result}, 64'd0);
      check("R8", "busy add carry", {63'd0, carry_out}, 64'd1);
      saw_extra = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk); #1;
         if (done) saw_extra = 1'b1;
      end
      check("R8", "no extra done", {63'd0, saw_extra}, 64'd0);
      check("R8", "result unchanged", {32'd0, result}, 64'd0);
   endtask

   initial begin
      #10_000_000;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_logic();
      t_modifiers();
      t_unused();
      t_add_directed();
      t_add_random();
      t_busy();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule